// File: doc/BRIEF.md
# Eight-Level Programmable Priority Interrupt Resolver

This block watches eight level-sensitive interrupt request lines and decides which one should be served next. It raises one combined interrupt line toward a processor. When the processor answers with an acknowledge pulse, the block reports the number of the winning level on its read data port and records that level as in service. A higher-priority request can still break through while a level is in service. Lower or equal ones are held back until software retires the in-service level with an end-of-interrupt command.

Software reaches the block through a small register port: a two-bit address, eight-bit write data, read and write strobes, and registered read data. Through it software does the following:

- chooses one of three priority orderings at run time: fixed, rotate-after-service, or a software-named lowest level;
- loads and reads back a per-level mask;
- reads the captured request lines and the in-service set.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the mask register and the in-service register read 0, the interrupt output is low, and the fixed ordering is active (level 0 highest, level 7 lowest).
- R2: The request lines are captured on every clock edge. A read at address 0 returns the captured lines on `rdata` (bit i = line i) in the cycle after the read strobe.
- R3: A write to address 1 loads the mask (bit i = 1 masks level i), and a read of address 1 returns it. A masked level never raises `irq_out` and never wins an acknowledge.
- R4: In fixed ordering the lowest-numbered unmasked pending level wins.
- R5: An acknowledge while `irq_out` is high sets the winner's bit in the in-service register, which reads at address 2. It also places the winner's 3-bit number, zero-extended, on `rdata` in the next cycle.
- R6: An acknowledge while `irq_out` is low returns 0x80 on `rdata` and leaves the in-service register unchanged.
- R7: `irq_out` is high only when an unmasked pending level ranks strictly above every in-service level.
- R8: Writing command 0x80 (bits 7:5 = 100) to address 0 is an end-of-interrupt. It clears the highest-ranked in-service bit. With nothing in service it has no effect.
- R9: Command 0x40 (bits 7:5 = 010) selects rotate-after-service. In this mode an end-of-interrupt also makes the retired level the lowest rank, so the level one above it becomes highest.
- R10: Command 0x60 + L (bits 7:5 = 011, bits 2:0 = L) selects software-named ordering with L as the lowest level. Ranks then run L+1, L+2, … modulo 8 from highest. An end-of-interrupt leaves L unchanged.
- R11: Command 0x20 (bits 7:5 = 001) restores fixed ordering. Command codes other than 001, 010, 011 and 100 change nothing. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data / acknowledged level |
| irq_out | output | 1 | Combined interrupt request |
| ack_in | input | 1 | Interrupt acknowledge pulse |

## Verification
The bench aims at the orderings that differ between modes. In rotate mode, level 3 must beat level 0 after level 0 was retired; a resolver that kept the fixed order would report 0. In named-lowest mode, level 6 must beat level 0 and level 4 must beat level 5; a design that rotated the wrong way would report 0 or 5. It also holds a request back behind an in-service level of higher or equal rank. A resolver that ignored the in-service set would raise the interrupt there too early. Spurious acknowledges, end-of-interrupt on an empty set, masked requests and unknown command codes are driven to catch a design that would corrupt the in-service set or leak a masked level.

// File: rtl/pir_pkg.sv
package pir_pkg;

  typedef enum logic [1:0] {
    MODE_NESTED   = 2'd0,
    MODE_ROTATE   = 2'd1,
    MODE_SPECIFIC = 2'd2
  } prio_mode_e;

  // command opcodes carried in the three top bits of a write to ADDR_CMD
  localparam logic [2:0] OP_NESTED   = 3'b001;
  localparam logic [2:0] OP_ROTATE   = 3'b010;
  localparam logic [2:0] OP_SPECIFIC = 3'b011;
  localparam logic [2:0] OP_EOI      = 3'b100;

  localparam int ADDR_CMD  = 0;  // write: command, read: captured requests
  localparam int ADDR_MASK = 1;
  localparam int ADDR_ISR  = 2;

endpackage

// File: rtl/pir_pick.sv
// Finds the highest-ranked set bit of vec, where rank 0 belongs to
// level low+1 and rank N-1 to level low (modulo N). N must be a power of two.
module pir_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] low,
  output logic          found,
  output logic [LW-1:0] level,
  output logic [LW-1:0] rank
);

  logic [N-1:0] rot;

  generate
    for (genvar k = 0; k < N; k++) begin : g_rot
      logic [LW-1:0] src;
      assign src    = LW'(k) + low + LW'(1);
      assign rot[k] = vec[src];
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    rank  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) begin
        found = 1'b1;
        rank  = LW'(k);
      end
    end
  end

  assign level = rank + low + LW'(1);

endmodule

// File: rtl/pir_cmd_dec.sv
module pir_cmd_dec
  import pir_pkg::*;
#(
  parameter int AW = 2,
  parameter int LW = 3
) (
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    op,
  input  logic [LW-1:0] low_field,
  output logic          mask_we,
  output logic          mode_we,
  output prio_mode_e    mode_val,
  output logic [LW-1:0] low_val,
  output logic          eoi
);

  assign low_val = low_field;

  always_comb begin
    mask_we  = 1'b0;
    mode_we  = 1'b0;
    mode_val = MODE_NESTED;
    eoi      = 1'b0;
    if (wr_en) begin
      if (addr == AW'(ADDR_MASK)) begin
        mask_we = 1'b1;
      end else if (addr == AW'(ADDR_CMD)) begin
        case (op)
          OP_NESTED:   mode_we = 1'b1;
          OP_ROTATE:   begin mode_we = 1'b1; mode_val = MODE_ROTATE;   end
          OP_SPECIFIC: begin mode_we = 1'b1; mode_val = MODE_SPECIFIC; end
          OP_EOI:      eoi = 1'b1;
          default:     ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import pir_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_out,
  input  logic          ack_in
);

  localparam int            LW   = $clog2(N);
  localparam logic [DW-1:0] SPUR = {1'b1, {(DW-1){1'b0}}};

  // state
  logic [N-1:0]  irr_q, isr_q, mask_q;
  prio_mode_e    mode_q;
  logic [LW-1:0] low_q;
  logic [DW-1:0] rdata_q;

  // next state
  logic [N-1:0]  irr_d, isr_d, mask_d;
  prio_mode_e    mode_d;
  logic [LW-1:0] low_d;
  logic [DW-1:0] rdata_d;
  logic          mask_en, mode_en, low_en, rdata_en;

  // decode
  logic          mask_we, mode_we, eoi;
  prio_mode_e    mode_val;
  logic [LW-1:0] low_val;

  // resolution
  logic [N-1:0]  eligible, win_hot, clr_hot;
  logic          req_found, isr_found, win, ack_hit;
  logic [LW-1:0] req_level, req_rank, isr_level, isr_rank;

  pir_cmd_dec #(.AW(AW), .LW(LW)) u_dec (
    .wr_en     (wr_en),
    .addr      (addr),
    .op        (wdata[DW-1 -: 3]),
    .low_field (wdata[LW-1:0]),
    .mask_we   (mask_we),
    .mode_we   (mode_we),
    .mode_val  (mode_val),
    .low_val   (low_val),
    .eoi       (eoi)
  );

  assign eligible = irr_q & ~mask_q;

  pir_pick #(.N(N), .LW(LW)) u_req_pick (
    .vec   (eligible),
    .low   (low_q),
    .found (req_found),
    .level (req_level),
    .rank  (req_rank)
  );

  pir_pick #(.N(N), .LW(LW)) u_isr_pick (
    .vec   (isr_q),
    .low   (low_q),
    .found (isr_found),
    .level (isr_level),
    .rank  (isr_rank)
  );

  assign win     = req_found && (!isr_found || (req_rank < isr_rank));
  assign ack_hit = ack_in && win;
  assign irq_out = win;
  assign rdata   = rdata_q;

  always_comb begin
    win_hot = ack_hit ? (N'(1) << req_level) : '0;
    clr_hot = (eoi && isr_found) ? (N'(1) << isr_level) : '0;

    irr_d   = req_in & ~win_hot;
    isr_d   = (isr_q & ~clr_hot) | win_hot;

    mask_en = mask_we;
    mask_d  = wdata[N-1:0];

    mode_en = mode_we;
    mode_d  = mode_val;

    low_en  = 1'b0;
    low_d   = low_q;
    if (mode_we) begin
      low_en = 1'b1;
      case (mode_val)
        MODE_NESTED:   low_d = LW'(N - 1);
        MODE_SPECIFIC: low_d = low_val;
        default:       low_d = low_q;
      endcase
    end else if (eoi && isr_found && (mode_q == MODE_ROTATE)) begin
      low_en = 1'b1;
      low_d  = isr_level;
    end

    rdata_en = ack_in | rd_en;
    if (ack_in) begin
      rdata_d = win ? DW'(req_level) : SPUR;
    end else begin
      case (addr)
        AW'(ADDR_CMD):  rdata_d = DW'(irr_q);
        AW'(ADDR_MASK): rdata_d = DW'(mask_q);
        AW'(ADDR_ISR):  rdata_d = DW'(isr_q);
        default:        rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q   <= '0;
      isr_q   <= '0;
      mask_q  <= '0;
      mode_q  <= MODE_NESTED;
      low_q   <= LW'(N - 1);
      rdata_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      if (mask_en)  mask_q  <= mask_d;
      if (mode_en)  mode_q  <= mode_d;
      if (low_en)   low_q   <= low_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_in,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [2:0]    op_field,
  input logic [DW-1:0] rdata,
  input logic          irq_out,
  input logic [N-1:0]  irr_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  mask_q,
  input logic [1:0]    mode_q,
  input logic [$clog2(N)-1:0] low_q
);

  logic eoi_w;
  assign eoi_w = wr_en && (addr == '0) && (op_field == 3'b100);

  // R1 R4
  nested_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> (low_q == $clog2(N)'(N - 1)));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|(irr_q & ~mask_q)));

  // R2
  pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ack_in && addr == '0) |=> (rdata[N-1:0] == $past(irr_q)));

  // R5
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && irq_out && !eoi_w) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  // R6
  spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !irq_out) |=> (rdata == {1'b1, {(DW-1){1'b0}}}));

  // R6
  spurious_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !irq_out && !eoi_w) |=> $stable(isr_q));

  // R8
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_w && !ack_in && (|isr_q)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_in   (ack_in),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .op_field (wdata[DW-1 -: 3]),
  .rdata    (rdata),
  .irq_out  (irq_out),
  .irr_q    (irr_q),
  .isr_q    (isr_q),
  .mask_q   (mask_q),
  .mode_q   (mode_q),
  .low_q    (low_q)
);

// File: tb/test_irq_prio_resolver.sv
module test_irq_prio_resolver;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_in;
  logic          wr_en, rd_en, ack_in;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [DW-1:0] v;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  irq_prio_resolver #(.N(N), .DW(DW), .AW(AW)) i_irq_prio_resolver (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (req_in),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq_out (irq_out),
    .ack_in  (ack_in)
  );

  task automatic tally(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every read or acknowledge yields one rdata result
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      if (rd_en || ack_in) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          tally(1'b0, "R5 unexpected result", rdata, '0);
        end else begin
          e = sb.pop_front();
          tally(rdata === e.v, e.tag, rdata, e.v);
        end
      end
    end
  end

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic exp_read(logic [AW-1:0] a, logic [DW-1:0] v, string tag);
    exp_t e;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    e.v = v; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic exp_ack(logic [DW-1:0] v, string tag);
    exp_t e;
    @(negedge clk);
    ack_in = 1'b1;
    e.v = v; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    ack_in = 1'b0;
  endtask

  task automatic set_req(logic [N-1:0] v);
    @(negedge clk);
    req_in = v;
    @(negedge clk);
  endtask

  task automatic chk_int(bit exp, string tag);
    tally(irq_out === exp, tag, DW'(irq_out), DW'(exp));
  endtask

  localparam logic [DW-1:0] EOI = 8'h80;

  initial begin
    rst_n = 1'b0; req_in = '0; wr_en = 1'b0; rd_en = 1'b0; ack_in = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk_int(1'b0, "R1 irq after reset");
    exp_read(2'd1, 8'h00, "R1 mask after reset");
    exp_read(2'd2, 8'h00, "R1 isr after reset");
    exp_read(2'd3, 8'h00, "R11 address 3 reads zero");

    set_req(8'hA4);
    exp_read(2'd0, 8'hA4, "R2 pending lines");
    chk_int(1'b1, "R4 irq raised");
    exp_ack(8'h02, "R5 fixed winner level 2");
    exp_read(2'd2, 8'h04, "R5 isr after ack");
    chk_int(1'b0, "R7 lower levels held back");
    set_req(8'hA5);
    chk_int(1'b1, "R7 higher level breaks through");
    exp_ack(8'h00, "R4 level 0 wins");
    exp_read(2'd2, 8'h05, "R5 isr nested");
    set_req(8'hA0);
    do_write(2'd0, EOI);
    exp_read(2'd2, 8'h04, "R8 eoi clears highest");
    chk_int(1'b0, "R7 still held behind level 2");
    set_req(8'h00);
    do_write(2'd0, EOI);
    exp_read(2'd2, 8'h00, "R8 eoi clears last");
    do_write(2'd0, EOI);
    exp_read(2'd2, 8'h00, "R8 eoi on empty set");

    do_write(2'd1, 8'h01);
    exp_read(2'd1, 8'h01, "R3 mask readback");
    set_req(8'h01);
    chk_int(1'b0, "R3 masked level quiet");
    set_req(8'h03);
    chk_int(1'b1, "R3 unmasked level raises");
    exp_ack(8'h01, "R3 masked level skipped");
    set_req(8'h00);
    do_write(2'd0, EOI);
    do_write(2'd1, 8'h00);

    exp_ack(8'h80, "R6 spurious ack code");
    exp_read(2'd2, 8'h00, "R6 isr unchanged");

    do_write(2'd0, 8'h40);
    set_req(8'h09);
    exp_ack(8'h00, "R9 first service level 0");
    set_req(8'h08);
    do_write(2'd0, EOI);
    set_req(8'h09);
    exp_ack(8'h03, "R9 rotated level 3 beats 0");
    set_req(8'h01);
    do_write(2'd0, EOI);
    set_req(8'h11);
    exp_ack(8'h04, "R9 level 4 after 3 retired");
    set_req(8'h00);
    do_write(2'd0, EOI);

    do_write(2'd0, 8'h65);
    set_req(8'h61);
    exp_ack(8'h06, "R10 level 6 top when 5 lowest");
    set_req(8'h21);
    chk_int(1'b0, "R7 level 0 ranks below 6");
    do_write(2'd0, EOI);
    exp_ack(8'h00, "R10 level 0 next");
    set_req(8'h30);
    do_write(2'd0, EOI);
    exp_ack(8'h04, "R10 level 4 beats lowest 5");
    set_req(8'h00);
    do_write(2'd0, EOI);

    do_write(2'd0, 8'h20);
    set_req(8'h81);
    exp_ack(8'h00, "R4 fixed order restored");
    do_write(2'd0, 8'hE0);
    exp_read(2'd2, 8'h01, "R11 unknown opcode ignored");
    do_write(2'd0, 8'h00);
    exp_read(2'd2, 8'h01, "R11 zero opcode ignored");
    chk_int(1'b0, "R7 level 7 held behind 0");
    set_req(8'h80);
    do_write(2'd0, EOI);
    chk_int(1'b1, "R8 release after eoi");
    exp_ack(8'h07, "R11 mode kept after ignored codes");
    set_req(8'h00);

    repeat (3) @(negedge clk);
    if (sb.size() != 0) tally(1'b0, "R5 missing results", DW'(sb.size()), '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule